// File: doc/BRIEF.md
# Oscillator Start-up Stabilization Controller

This block decides when a crystal oscillator clock may be used as the root clock of a chip. Once the oscillator is switched on, a stabilization counter that runs on the oscillator clock counts up to a programmable threshold. The threshold is an 8-bit field scaled by 512. When the threshold is reached, an "available" flag goes high and stays high. On that same edge a sticky status bit latches the event. The interrupt output is that status bit gated by a mask bit.

Software reaches the block through a small synchronous register port with two word addresses: a control word and a status word. The control word also holds a bypass bit. Setting it selects an external clock input as the root clock and holds the counter in reset. Software cannot clear the bypass bit; only a system reset does. The register port and the counter share one clock. Synchronizers and the clock multiplexer itself are outside this block.

Top module: `osc_startup_ctrl`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (end-of-count field = 1, bypass = 0, mask = 0). The status word reads 0. `root_sel`, `clk_avail` and `irq` are 0.
- R2: Writing 1 to control bit 31 sets bypass, and `root_sel` follows it (1 = external clock). Writing 0 to bit 31 leaves bypass set. Only reset clears it.
- R3: While `osc_on` is low the counter is cleared and `clk_avail` is 0. Each off-to-on transition restarts the count from zero, including one that interrupts a count in progress.
- R4: With end-of-count N in control bits 23:16, `clk_avail` rises exactly N*512+1 clock edges after `osc_on` is first sampled high. For N = 0 that is after one edge.
- R5: While bypass is set, `clk_avail` stays 0 whatever `osc_on` does.
- R6: Once `clk_avail` is high, it stays high as long as `osc_on` stays high and bypass is clear.
- R7: Status word bit 0 is set on the edge where `clk_avail` rises. Writing 1 to it clears it and writing 0 has no effect. A set on the same edge as a clearing write wins.
- R8: `irq` equals status bit 0 AND the mask in control bit 15.
- R9: Control bits 30:24 and 14:8 are reserved. They have no function and read back the last value written to them. Bits 7:0 read 0 and ignore writes.
- R10: The end-of-count field and the mask bit read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also clocks the register port |
| rst_n | input | 1 | Active-low system reset, synchronous |
| reg_sel | input | 1 | Word select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| osc_on | input | 1 | Oscillator enable |
| root_sel | output | 1 | Root clock select: 0 oscillator, 1 external input |
| clk_avail | output | 1 | Oscillator clock is stable and usable |
| irq | output | 1 | Masked oscillator-available interrupt |

## Verification
The counter is started with thresholds 0, 1, 2 and 3 and with random thresholds between 0 and 2, each under random mask and reserved-bit values. The available edge is checked one cycle before and exactly at N*512+1, which separates an off-by-one from a correct count. A start that is cut short and then restarted tells a counter that clears on switch-off from one that only pauses. A status clear issued on the very edge of the event tells which of set and clear has priority. Bypass writes of 1 and then 0, followed by a long enabled period, tell a sticky, counter-holding bypass from a plain read/write bit.

// File: rtl/osc_startup_pkg.sv
`timescale 1ns/1ps
package osc_startup_pkg;

   localparam int CTL_W    = 32;
   localparam int BYP_POS  = 31;
   localparam int EOC_W    = 8;
   localparam int EOC_LSB  = 16;
   localparam int MASK_POS = 15;
   localparam int RHI_LSB  = 24;
   localparam int RHI_W    = 7;
   localparam int RLO_LSB  = 8;
   localparam int RLO_W    = 7;
   localparam int STS_POS  = 0;
   localparam logic [EOC_W-1:0] EOC_RST = 8'h01;

   typedef struct packed {
      logic             byp;
      logic [EOC_W-1:0] eoc;
      logic             mask;
   } ctl_t;

   // assemble the control word seen on the read port
   function automatic logic [CTL_W-1:0] ctl_word(input ctl_t c,
                                                 input logic [RHI_W-1:0] rhi,
                                                 input logic [RLO_W-1:0] rlo);
      logic [CTL_W-1:0] w;
      w                     = '0;
      w[BYP_POS]            = c.byp;
      w[RHI_LSB +: RHI_W]   = rhi;
      w[EOC_LSB +: EOC_W]   = c.eoc;
      w[MASK_POS]           = c.mask;
      w[RLO_LSB +: RLO_W]   = rlo;
      return w;
   endfunction

endpackage

// File: rtl/osc_ctl_regs.sv
`timescale 1ns/1ps
module osc_ctl_regs
   import osc_startup_pkg::*;
#(
   parameter bit RSV_KEEP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic [CTL_W-1:0] wdata,
   output ctl_t             ctl,
   output logic [RHI_W-1:0] rsv_hi,
   output logic [RLO_W-1:0] rsv_lo
);

   logic             byp_q;
   logic [EOC_W-1:0] eoc_q;
   logic             mask_q;

   // bypass: set-only from software, cleared by reset alone
   always_ff @(posedge clk) begin
      if (!rst_n)
         byp_q <= 1'b0;
      else if (wr_ctl && wdata[BYP_POS])
         byp_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eoc_q  <= EOC_RST;
         mask_q <= 1'b0;
      end else if (wr_ctl) begin
         eoc_q  <= wdata[EOC_LSB +: EOC_W];
         mask_q <= wdata[MASK_POS];
      end
   end

   assign ctl.byp  = byp_q;
   assign ctl.eoc  = eoc_q;
   assign ctl.mask = mask_q;

   // reserved fields: either hold what was written or read as zero
   generate
      if (RSV_KEEP) begin : g_rsv_store
         logic [RHI_W-1:0] rhi_q;
         logic [RLO_W-1:0] rlo_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rhi_q <= '0;
               rlo_q <= '0;
            end else if (wr_ctl) begin
               rhi_q <= wdata[RHI_LSB +: RHI_W];
               rlo_q <= wdata[RLO_LSB +: RLO_W];
            end
         end
         assign rsv_hi = rhi_q;
         assign rsv_lo = rlo_q;
      end else begin : g_rsv_zero
         assign rsv_hi = '0;
         assign rsv_lo = '0;
      end
   endgenerate

   AST_BYP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |=> byp_q); // R2

endmodule

// File: rtl/osc_stab_counter.sv
`timescale 1ns/1ps
module osc_stab_counter #(
   parameter int unsigned EOC_BITS   = 8,
   parameter int unsigned SCALE_LOG2 = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                hold,
   input  logic [EOC_BITS-1:0] eoc,
   output logic                avail,
   output logic                avail_rise
);

   localparam int unsigned CNT_W = EOC_BITS + SCALE_LOG2;

   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] cnt_q;
   logic             avail_q;
   logic             active;
   logic             reached;

   // threshold = eoc * 2**SCALE_LOG2; a zero-width shift needs its own variant
   generate
      if (SCALE_LOG2 == 0) begin : g_unscaled
         assign target = eoc;
      end else begin : g_scaled
         assign target = {eoc, {SCALE_LOG2{1'b0}}};
      end
   endgenerate

   assign active     = run && !hold;
   assign reached    = (cnt_q >= target);
   assign avail_rise = active && !avail_q && reached;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         avail_q <= 1'b0;
      end else if (!active) begin
         cnt_q   <= '0;
         avail_q <= 1'b0;
      end else if (!avail_q) begin
         if (reached)
            avail_q <= 1'b1;
         else
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign avail = avail_q;

   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0) && !avail_q); // R3

   AST_BYPASS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt_q == '0) && !avail_q); // R5

   AST_RISE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(avail_q) |-> ($past(cnt_q) >= $past(target))); // R4

   AST_AVAIL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (avail_q && run && !hold) |=> (avail_q && $stable(cnt_q))); // R6

endmodule

// File: rtl/osc_irq_status.sv
`timescale 1ns/1ps
module osc_irq_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   output logic status
);

   logic sts_q;

   // a set on the same edge as a clear takes priority
   always_ff @(posedge clk) begin
      if (!rst_n)
         sts_q <= 1'b0;
      else if (set_evt)
         sts_q <= 1'b1;
      else if (clr_evt)
         sts_q <= 1'b0;
   end

   assign status = sts_q;

   AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q) |-> $past(set_evt)); // R7

   AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && !set_evt) |=> !sts_q); // R7

endmodule

// File: rtl/osc_startup_ctrl.sv
`timescale 1ns/1ps
module osc_startup_ctrl
   import osc_startup_pkg::*;
#(
   parameter int unsigned SCALE_LOG2 = 9,
   parameter bit          RSV_KEEP   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_sel,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        osc_on,
   output logic        root_sel,
   output logic        clk_avail,
   output logic        irq
);

   initial begin
      if (SCALE_LOG2 > 16)
         $fatal(1, "osc_startup_ctrl: SCALE_LOG2 must not exceed 16");
   end

   ctl_t             ctl;
   logic [RHI_W-1:0] rsv_hi;
   logic [RLO_W-1:0] rsv_lo;
   logic             wr_ctl;
   logic             wr_sts;
   logic             avail;
   logic             avail_rise;
   logic             sts;

   assign wr_ctl = reg_wr && !reg_sel;
   assign wr_sts = reg_wr &&  reg_sel;

   osc_ctl_regs #(
      .RSV_KEEP (RSV_KEEP)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctl (wr_ctl),
      .wdata  (reg_wdata),
      .ctl    (ctl),
      .rsv_hi (rsv_hi),
      .rsv_lo (rsv_lo)
   );

   osc_stab_counter #(
      .EOC_BITS   (EOC_W),
      .SCALE_LOG2 (SCALE_LOG2)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (osc_on),
      .hold       (ctl.byp),
      .eoc        (ctl.eoc),
      .avail      (avail),
      .avail_rise (avail_rise)
   );

   osc_irq_status u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (avail_rise),
      .clr_evt (wr_sts && reg_wdata[STS_POS]),
      .status  (sts)
   );

   always_comb begin
      if (reg_sel) begin
         reg_rdata          = '0;
         reg_rdata[STS_POS] = sts;
      end else begin
         reg_rdata = ctl_word(ctl, rsv_hi, rsv_lo);
      end
   end

   assign root_sel  = ctl.byp;
   assign clk_avail = avail;
   assign irq       = sts && ctl.mask;

   AST_ROOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      root_sel |=> root_sel); // R2

   AST_NO_AVAIL_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(root_sel) |-> !clk_avail); // R5

endmodule

// File: tb/osc_startup_ctrl_test.sv
`timescale 1ns/1ps
module osc_startup_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_sel;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        osc_on;
   logic        root_sel;
   logic        clk_avail;
   logic        irq;

   always #5 clk = ~clk;

   osc_startup_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .osc_on    (osc_on),
      .root_sel  (root_sel),
      .clk_avail (clk_avail),
      .irq       (irq)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // bench model of the register contents
   logic       m_byp;
   logic [6:0] m_rhi;
   logic [7:0] m_eoc;
   logic       m_mask;
   logic [6:0] m_rlo;
   logic       m_sts;

   function automatic logic [31:0] exp_ctl();
      return {m_byp, m_rhi, m_eoc, m_mask, m_rlo, 8'h00};
   endfunction

   function automatic logic exp_irq();
      return m_sts & m_mask;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_reset();
      m_byp = 0; m_rhi = 0; m_eoc = 8'h01; m_mask = 0; m_rlo = 0; m_sts = 0;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (!sel) begin
         m_byp  = m_byp | d[31];
         m_rhi  = d[30:24];
         m_eoc  = d[23:16];
         m_mask = d[15];
         m_rlo  = d[14:8];
      end else if (d[0]) begin
         m_sts = 1'b0;
      end
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      reg_sel = sel;
      #1;
      v = reg_rdata;
   endtask

   // switch on from off and check the exact edge where availability appears
   task automatic avail_run(input string req);
      int tgt;
      tgt = int'(m_eoc) * 512;
      osc_on = 1'b1;
      step(tgt);
      chk({req, " avail before target"}, {31'd0, clk_avail}, 32'd0);
      step(1);
      chk({req, " avail at target"}, {31'd0, clk_avail}, 32'd1);
      m_sts = 1'b1;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] d;
      void'($urandom(32'h0005_EED5));
      rst_n = 0; reg_sel = 0; reg_wr = 0; reg_wdata = '0; osc_on = 0;
      model_reset();
      step(3);
      rst_n = 1;
      step(1);

      // R1 reset state
      rd(1'b0, v); chk("R1 ctl reset", v, 32'h0001_0000);
      rd(1'b1, v); chk("R1 sts reset", v, 32'h0);
      chk("R1 outputs", {29'd0, root_sel, clk_avail, irq}, 32'd0);

      // R4 default threshold 1, R8 masked
      avail_run("R4 eoc1");
      chk("R8 masked irq", {31'd0, irq}, {31'd0, exp_irq()});
      rd(1'b1, v); chk("R7 status set", v, {31'd0, m_sts});
      step(5);
      chk("R6 avail held", {31'd0, clk_avail}, 32'd1);

      // R8 unmask, R10 readback
      wr(1'b0, 32'h0001_8000);
      rd(1'b0, v); chk("R10 mask readback", v, exp_ctl());
      chk("R8 unmasked irq", {31'd0, irq}, 32'd1);

      // R7 write 0 no effect, write 1 clears
      wr(1'b1, 32'h0);
      rd(1'b1, v); chk("R7 write0 ignored", v, 32'h1);
      wr(1'b1, 32'h1);
      rd(1'b1, v); chk("R7 w1c", v, 32'h0);
      chk("R8 irq after clear", {31'd0, irq}, 32'd0);

      // R3 switch off clears
      osc_on = 0; step(1);
      chk("R3 off drops avail", {31'd0, clk_avail}, 32'd0);

      // R4 threshold 3
      wr(1'b0, 32'h0003_8000);
      avail_run("R4 eoc3");
      chk("R8 irq eoc3", {31'd0, irq}, 32'd1);
      wr(1'b1, 32'h1);

      // R3 interrupted start restarts from zero
      osc_on = 0; step(1);
      wr(1'b0, 32'h0002_0000);
      osc_on = 1; step(700);
      osc_on = 0; step(2);
      avail_run("R3 restart");

      // R4 threshold 0 corner
      osc_on = 0; step(1);
      wr(1'b1, 32'h1);
      wr(1'b0, 32'h0000_8000);
      avail_run("R4 eoc0");
      chk("R8 irq eoc0", {31'd0, irq}, 32'd1);

      // R7 set wins over simultaneous clear
      osc_on = 0; step(1);
      wr(1'b1, 32'h1);
      reg_sel = 1; reg_wdata = 32'h1; reg_wr = 1; osc_on = 1;
      @(negedge clk);
      reg_wr = 0;
      m_sts = 1;
      rd(1'b1, v); chk("R7 set beats clear", v, 32'h1);

      // R9 reserved bits
      osc_on = 0; step(1);
      wr(1'b0, 32'h7F00_7FFF);
      rd(1'b0, v); chk("R9 reserved readback", v, 32'h7F00_7F00);
      wr(1'b0, 32'h2A01_55AA);
      rd(1'b0, v); chk("R9 reserved pattern", v, exp_ctl());

      // random configurations
      for (int i = 0; i < 10; i++) begin
         osc_on = 0;
         step(1 + ($urandom % 3));
         d = $urandom;
         d[31] = 1'b0;
         d[23:16] = 8'($urandom % 3);
         wr(1'b0, d);
         rd(1'b0, v); chk("R10 R9 random readback", v, exp_ctl());
         wr(1'b1, 32'h1);
         rd(1'b1, v); chk("R7 random clear", v, 32'h0);
         avail_run("R4 random");
         chk("R8 random irq", {31'd0, irq}, {31'd0, exp_irq()});
         step($urandom % 4);
         chk("R6 random hold", {31'd0, clk_avail}, 32'd1);
      end

      // R2 / R5 bypass
      osc_on = 0; step(1);
      wr(1'b0, 32'h8001_0000);
      chk("R2 root_sel set", {31'd0, root_sel}, 32'd1);
      osc_on = 1; step(600);
      chk("R5 bypass holds counter", {31'd0, clk_avail}, 32'd0);
      wr(1'b0, 32'h0001_0000);
      rd(1'b0, v); chk("R2 write0 keeps bypass", v, exp_ctl());
      chk("R2 root_sel kept", {31'd0, root_sel}, 32'd1);
      step(10);
      chk("R5 still held", {31'd0, clk_avail}, 32'd0);

      osc_on = 0; rst_n = 0; step(2);
      rst_n = 1; model_reset(); step(1);
      chk("R2 reset clears bypass", {31'd0, root_sel}, 32'd0);
      rd(1'b0, v); chk("R1 ctl after second reset", v, 32'h0001_0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R4 actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule